// File: doc/BRIEF.md
# Serial Switch-Enable Register with Chained Output

This block holds the on/off state of eight independent switch enables and is written over a three-wire serial port: an active-low frame strobe, a serial clock and a serial data input. While the strobe is low, each falling edge of the serial clock moves one data bit into an 8-bit input register, most significant bit first. The enable outputs stay fixed for the whole frame. They take the input register's contents only when the strobe rises, so every switch changes at the same moment.

The bit that leaves the top of the input register is sent out on a chain output. It changes on the serial clock's rising edge, so a second unit wired downstream can sample it on the next falling edge. Several units can share one strobe and one clock. A frame of eight clocks per unit then loads all of them, and they latch together. Frames of any length are accepted, and the register always keeps the last eight bits that arrived. The serial inputs are oversampled by a faster system clock through two-flop synchronizers, so the serial clock may run at no more than a quarter of the system clock rate. The chain output is modelled as a pull-low enable that releases the line when the outgoing bit is 1.

Top module: `sws_top`

## Requirements
- R1: While `rstN` is low, asynchronously and without any clock, the input register, the enable register and the outgoing bit are all zero. The outputs then show `swEnable` = 0 (all switches off) and `chainPullLow` = 1.
- R2: In a frame, the first bit sent ends up in bit 7 of the latched word. Bit i drives `swEnable[i]` (switch i+1). A 1 turns that switch on and a 0 turns it off, and any combination is allowed, including all on and all off.
- R3: The input register shifts left by one, taking `sdi` into bit 0, on each falling edge of `sclk` seen while `frameN` is low. It shifts at no other time.
- R4: `swEnable` holds its value throughout a frame. On the rising edge of `frameN` it loads the input register contents, and it changes at no other time.
- R5: A frame may be longer or shorter than eight clocks. The latched word is always the last eight bits shifted in. With fewer clocks, the earlier contents move up by the number of clocks.
- R6: While `frameN` is high, edges on `sclk` and `sdi` leave the input register unchanged.
- R7: A frame with no serial clock edges latches the unchanged input register, so `swEnable` keeps its value.
- R8: On each rising edge of `sclk`, the outgoing bit takes bit 7 of the input register. `chainPullLow` is the inverse of that bit. During a new frame the previously held word therefore appears on the line MSB first, eight clocks behind the input.
- R9: An edge on a serial input takes effect at the third rising edge of `clk` after the input changes (two synchronizer stages plus one edge-detect stage).
- R10: In a chain of two units, a frame of 16 clocks loads the downstream unit with the first eight bits and the upstream unit with the last eight. Both units latch on the same strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| swEnable | output | 8 | Switch enables, 1 = on |
| chainPullLow | output | 1 | Drive-low enable for the chain line (1 = pull low) |

## Verification
The bench targets frames of the wrong length and clock activity with the strobe high. A design that counted clocks, or that shifted when it should not, would latch a different word from the last eight bits. It checks that the enables stay fixed in the middle of a frame, where a design updating on each clock would show partial words. It reads the old word back on the chain line and runs a two-unit chain, where a launch on the wrong edge, or a tap on the wrong bit, shifts the downstream word by one position. It also measures the three-cycle latency from a strobe edge and checks that reset clears the outputs without a clock.

// File: rtl/sws_pkg.sv
package sws_pkg;
  // Strobes from the edge detector to the datapath, valid for one clk cycle
  typedef struct packed {
    logic shift;   // serial clock fell while the frame is active
    logic launch;  // serial clock rose
    logic latch;   // frame strobe rose
  } swsStrobe_t;
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       frameS,
  output swsStrobe_t strobe
);
  logic sclkPrev;
  logic framePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      framePrev <= 1'b1;
    end else begin
      sclkPrev  <= sclkS;
      framePrev <= frameS;
    end
  end

  always_comb begin
    strobe.shift  = sclkPrev & ~sclkS & ~frameS;
    strobe.launch = ~sclkPrev & sclkS;
    strobe.latch  = ~framePrev & frameS;
  end

  // R4: a strobe rise cannot repeat on the next cycle
  latch_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> !strobe.latch);
endmodule

// File: rtl/sws_datapath.sv
module sws_datapath
  import sws_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  swsStrobe_t       strobe,
  input  logic             dataS,
  output logic [WIDTH-1:0] swEn,
  output logic             outBit
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      swEn     <= '0;
      outBit   <= 1'b0;
    end else begin
      if (strobe.shift)  shiftReg <= {shiftReg[TOP-1:0], dataS};
      if (strobe.latch)  swEn     <= shiftReg;
      if (strobe.launch) outBit   <= shiftReg[TOP];
    end
  end

  // R4
  swen_latch_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swEn != $past(swEn)) |-> $past(strobe.latch));
  // R4
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (swEn == $past(shiftReg)));
  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(shiftReg));
  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (shiftReg[0] == $past(dataS)));
  // R8
  launch_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> (outBit == $past(shiftReg[TOP])));
endmodule

// File: rtl/sws_top.sv
module sws_top
  import sws_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             sclk,
  input  logic             sdi,
  output logic [WIDTH-1:0] swEnable,
  output logic             chainPullLow
);
  localparam int          NUM_IN  = 3;
  // index 0: serial clock, 1: frame strobe (idle high), 2: data
  localparam logic [NUM_IN-1:0] IDLE_VAL = 3'b010;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  swsStrobe_t        strobe;
  logic              outBit;

  assign rawIn = {sdi, frameN, sclk};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    sws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL[i])) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[i]),
      .dout(syncIn[i])
    );
  end

  sws_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclkS (syncIn[0]),
    .frameS(syncIn[1]),
    .strobe(strobe)
  );

  sws_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .dataS (syncIn[2]),
    .swEn  (swEnable),
    .outBit(outBit)
  );

  assign chainPullLow = ~outBit;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (swEnable == '0 && chainPullLow));
endmodule

// File: tb/tb_sws_top.sv
module tb_sws_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN, frameN, sclk, sdi;
  logic [7:0] swEnable, swEnable2;
  logic chainPullLow, chainPullLow2;
  logic chainLine;

  int checks = 0;
  int fails  = 0;
  logic [15:0] seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sws_top dut (.clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdi(sdi),
               .swEnable(swEnable), .chainPullLow(chainPullLow));
  assign chainLine = ~chainPullLow;
  sws_top dut2 (.clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdi(chainLine),
                .swEnable(swEnable2), .chainPullLow(chainPullLow2));

  // Behavioural reference: inputs seen two clocks late, edges judged against one clock before
  bit fQ[$], cQ[$], dQ[$];
  bit [7:0] mShift, mSw;
  bit mOut;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fQ = '{1, 1, 1}; cQ = '{0, 0, 0}; dQ = '{0, 0, 0};
      mShift = 0; mSw = 0; mOut = 0;
    end else begin
      bit fNow, fOld, cNow, cOld, dNow;
      bit [7:0] oldShift;
      fNow = fQ[1]; fOld = fQ[2]; cNow = cQ[1]; cOld = cQ[2]; dNow = dQ[1];
      oldShift = mShift;
      if (!cOld && cNow) mOut = oldShift[7];
      if (!fOld && fNow) mSw = oldShift;
      if (cOld && !cNow && !fNow) mShift = {oldShift[6:0], dNow};
      fQ.push_front(frameN); void'(fQ.pop_back());
      cQ.push_front(sclk);   void'(cQ.pop_back());
      dQ.push_front(sdi);    void'(dQ.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      checks++;
      if (swEnable !== mSw || chainPullLow !== ~mOut) begin
        fails++;
        $display("FAIL R9 model: actual sw=%h pull=%b expected sw=%h pull=%b",
                 swEnable, chainPullLow, mSw, ~mOut);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startFrame();
    frameN = 1'b0;
    waitN(HALF);
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    seen = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b1; sdi = v[i];
      waitN(HALF);
      seen = {seen[14:0], ~chainPullLow};
      sclk = 1'b0;
      waitN(HALF);
    end
  endtask

  task automatic endFrame();
    waitN(HALF);
    frameN = 1'b1;
    waitN(2 * HALF);
  endtask

  task automatic writeWord(input logic [15:0] v, input int n);
    startFrame(); sendBits(v, n); endFrame();
  endtask

  initial begin
    rstN = 1'b0; frameN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    waitN(5);
    check("R1 reset enables", 16'(swEnable), 16'h00);
    check("R1 reset line", 16'(chainPullLow), 16'h1);
    rstN = 1'b1;
    waitN(4);

    writeWord(16'hA5, 8); check("R2 pattern A5", 16'(swEnable), 16'hA5);
    writeWord(16'h01, 8); check("R2 switch1 only", 16'(swEnable), 16'h01);
    writeWord(16'hFF, 8); check("R2 all on", 16'(swEnable), 16'hFF);
    writeWord(16'h00, 8); check("R2 all off", 16'(swEnable), 16'h00);

    // R4: enables hold through the frame
    startFrame(); sendBits(16'h3C, 8);
    check("R4 mid-frame hold", 16'(swEnable), 16'h00);
    endFrame(); check("R4 latch on rise", 16'(swEnable), 16'h3C);

    // R8: old word read back MSB first on the line
    writeWord(16'h96, 8);
    startFrame(); sendBits(16'h5A, 8);
    check("R8 readback", seen & 16'hFF, 16'h96);
    endFrame(); check("R3 new word", 16'(swEnable), 16'h5A);

    // R5: long and short frames
    writeWord(16'hF3C, 12); check("R5 long frame", 16'(swEnable), 16'h3C);
    writeWord(16'h5, 3);    check("R5 short frame", 16'(swEnable), 16'hE5);

    // R6: clocking with frame high changes nothing
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; sdi = 1'b1; waitN(HALF);
      sclk = 1'b0; sdi = 1'b0; waitN(HALF);
    end
    check("R6 idle clocks", 16'(swEnable), 16'hE5);
    startFrame(); endFrame();
    check("R6 register untouched", 16'(swEnable), 16'hE5);
    startFrame(); endFrame();
    check("R7 empty frame", 16'(swEnable), 16'hE5);

    // R9: three-clock latency from strobe rise
    startFrame(); sendBits(16'h18, 8); waitN(HALF);
    frameN = 1'b1;
    waitN(2); check("R9 before third edge", 16'(swEnable), 16'hE5);
    waitN(1); check("R9 at third edge", 16'(swEnable), 16'h18);
    waitN(2 * HALF);

    // R10: two-unit chain, far unit's word first
    writeWord(16'hC381, 16);
    check("R10 near unit", 16'(swEnable), 16'h81);
    check("R10 far unit", 16'(swEnable2), 16'hC3);

    // R1: asynchronous clear mid-run
    @(negedge clk); #1 rstN = 1'b0; #1;
    check("R1 async clear", 16'(swEnable), 16'h00);
    check("R1 async line", 16'(chainPullLow), 16'h1);
    waitN(3); rstN = 1'b1; waitN(3);
    check("R1 after release", 16'(swEnable), 16'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule